// File: doc/BRIEF.md
# ADC Acquisition and Power Sequencer

This block is the control state machine between a two-wire serial front end and a successive-approximation converter core. The front end hands it a decoded control word (input channel, span, polarity, power-down request) with a strobe in the cycle the polarity bit is captured. From that strobe the block holds the track/hold in its tracking state and drives the mux and range selects. The stop strobe of the bus transaction closes the window, and a conversion of `BITS` bit decisions starts at once.

The conversion runs MSB first, one decision every `CLK_DIV` clocks. The block drives the trial code to the core's DAC and reads back one comparator bit. When the last decision is made it stores the result in an output register: raw binary for a unipolar span, two's complement for a bipolar span. A requested standby or full power-down is applied only once that result is stored. A wake strobe from an address-write match brings the core back. The active-low shutdown input stops everything at once. The stored result stays readable in every power state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, result is 0, result_valid, th_track and conv_busy are 0, and core_en and ref_buf_en are 1.
- R2: A cfg_strobe while the core is powered and no conversion runs sets th_track the next cycle, and mux_sel, rng_sel and bip_sel show cfg_chan, cfg_span and cfg_bip.
- R3: stop_strobe during acquisition clears th_track and sets conv_busy the next cycle. A stop_strobe with no acquisition open has no effect: conv_busy stays 0.
- R4: A conversion tests bit BITS-1 down to bit 0, one per CLK_DIV clocks. A trial bit is kept when cmp_in is 1 (input at or above sar_dac). conv_busy stays high for BITS*CLK_DIV+1 cycles and falls in the cycle result_valid pulses for one cycle.
- R5: With cfg_bip 0 the stored result equals the converted code unchanged (straight binary).
- R6: With cfg_bip 1 the stored result is the converted code with its MSB inverted (two's complement). For example, code 0x800 reads 0x000 and code 0x000 reads 0x800.
- R7: cfg_pd 00 or 01 keeps core_en and ref_buf_en at 1 after a conversion. cfg_pd 10 (standby) gives core_en 0 and ref_buf_en 1 once the result is stored.
- R8: cfg_pd 11 (full power-down) gives core_en 0 and ref_buf_en 0 once the result is stored. core_en stays 1 while conv_busy is 1.
- R9: wake_strobe during a software power-down sets core_en and ref_buf_en to 1 the next cycle.
- R10: shdn_n low clears conv_busy, th_track, core_en and ref_buf_en the next cycle. The aborted conversion produces no result_valid and leaves result unchanged. One cycle after shdn_n returns high, core_en is 1.
- R11: In power-down, result holds the last stored value and a cfg_strobe is ignored: th_track stays 0.
- R12: A cfg_strobe during a conversion does not change mux_sel, rng_sel or bip_sel until the result is stored. The new word is then applied and acquisition opens. The finished conversion's power-down request is skipped, and the result is formatted with the old polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_strobe | input | 1 | Control word valid (polarity bit captured) |
| cfg_chan | input | 3 | Requested input channel |
| cfg_span | input | 1 | Full-scale span select |
| cfg_bip | input | 1 | 1 selects bipolar coding |
| cfg_pd | input | 2 | Power-down request: 0X on, 10 standby, 11 full |
| stop_strobe | input | 1 | Bus stop seen |
| wake_strobe | input | 1 | Bit after a matching address with write |
| shdn_n | input | 1 | Active-low hardware shutdown |
| cmp_in | input | 1 | Comparator: input at or above sar_dac |
| th_track | output | 1 | Track/hold in tracking state |
| mux_sel | output | 3 | Input mux select |
| rng_sel | output | 1 | Span control to the input network |
| bip_sel | output | 1 | Polarity control to the input network |
| sar_dac | output | 12 | Trial code to the core DAC |
| conv_busy | output | 1 | Conversion running |
| core_en | output | 1 | Converter core powered |
| ref_buf_en | output | 1 | Reference buffer powered |
| result | output | 12 | Last stored, formatted result |
| result_valid | output | 1 | One-cycle pulse when result is updated |

## Verification
The comparator is modelled as a fixed input code compared with sar_dac. Conversions are run with codes at both rails, at the midscale pair 0x7FF/0x800, and at irregular bit patterns. Mid-range patterns show that every decision keeps or drops the correct bit. The rails and midscale values show whether the MSB inversion is tied to the polarity bit of the conversion, not to a word held during it. Each power request is followed by a readback of the enables and the held result. Shutdown is asserted in the middle of a conversion, which separates a clean abort from a late, spurious result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    parameter int unsigned SEL_W = 3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACQ,
        PH_CONV
    } phase_e;

    typedef enum logic [1:0] {
        PW_ON,
        PW_STBY,
        PW_FULL,
        PW_HARD
    } pwr_e;

    typedef struct packed {
        logic [SEL_W-1:0] chan;
        logic             span;
        logic             bip;
        logic [1:0]       pd;
    } cfg_t;

endpackage

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
    parameter int unsigned BITS    = 12,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic            cmp_in,
    output logic [BITS-1:0] trial,
    output logic            done,
    output logic [BITS-1:0] code
);
    localparam int unsigned IDX_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [DIV_W-1:0] div;
        logic [BITS-1:0]  trial;
        logic             done;
        logic [BITS-1:0]  code;
    } sar_t;

    sar_t s_d, s_q;
    logic [BITS-1:0] t_work;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        t_work   = s_q.trial;
        if (abort) begin
            s_d.busy = 1'b0;
        end else if (start) begin
            s_d.busy  = 1'b1;
            s_d.idx   = IDX_W'(BITS - 1);
            s_d.div   = '0;
            s_d.trial = MSB_ONLY;
        end else if (s_q.busy) begin
            if (s_q.div == DIV_W'(CLK_DIV - 1)) begin
                s_d.div = '0;
                if (!cmp_in) t_work[s_q.idx] = 1'b0;
                if (s_q.idx == '0) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.code = t_work;
                end else begin
                    t_work[s_q.idx - 1'b1] = 1'b1;
                    s_d.idx = s_q.idx - 1'b1;
                end
                s_d.trial = t_work;
            end else begin
                s_d.div = s_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trial = s_q.trial;
    assign done  = s_q.done;
    assign code  = s_q.code;

    // R4: every conversion begins with only the MSB on trial
    assert_trial_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (trial == MSB_ONLY));

    // R4: completion is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shdn_n,
    input  logic       apply,
    input  logic [1:0] pd_req,
    input  logic       wake,
    output logic       core_en,
    output logic       ref_buf_en
);
    pwr_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!shdn_n) begin
            st_d = PW_HARD;
        end else if (st_q == PW_HARD) begin
            st_d = PW_ON;
        end else if (st_q == PW_ON) begin
            if (apply && pd_req[1]) st_d = pd_req[0] ? PW_FULL : PW_STBY;
        end else if (wake) begin
            st_d = PW_ON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PW_ON;
        else        st_q <= st_d;
    end

    assign core_en    = (st_q == PW_ON);
    assign ref_buf_en = (st_q == PW_ON) || (st_q == PW_STBY);

    // R10: hardware shutdown removes both enables on the next cycle
    assert_hard_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!core_en && !ref_buf_en));

    // R9: wake from a software power-down restores the core
    assert_wake_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && wake && (st_q == PW_STBY || st_q == PW_FULL)) |=> core_en);

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
    parameter int unsigned BITS = 12
) (
    input  logic [BITS-1:0] raw,
    input  logic            bip,
    output logic [BITS-1:0] code
);
    always_comb begin
        code           = raw;
        code[BITS-1]   = raw[BITS-1] ^ bip;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned BITS    = 12,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_strobe,
    input  logic [SEL_W-1:0] cfg_chan,
    input  logic             cfg_span,
    input  logic             cfg_bip,
    input  logic [1:0]       cfg_pd,
    input  logic             stop_strobe,
    input  logic             wake_strobe,
    input  logic             shdn_n,
    input  logic             cmp_in,
    output logic             th_track,
    output logic [SEL_W-1:0] mux_sel,
    output logic             rng_sel,
    output logic             bip_sel,
    output logic [BITS-1:0]  sar_dac,
    output logic             conv_busy,
    output logic             core_en,
    output logic             ref_buf_en,
    output logic [BITS-1:0]  result,
    output logic             result_valid
);
    typedef struct packed {
        phase_e          phase;
        cfg_t            act;
        logic            pend_v;
        cfg_t            pend;
        logic [BITS-1:0] res;
        logic            res_v;
    } ctl_t;

    ctl_t c_d, c_q;
    cfg_t in_cfg;
    logic sar_start, sar_abort, sar_done, pd_apply;
    logic [BITS-1:0] sar_code, fmt_code;

    always_comb begin
        in_cfg.chan = cfg_chan;
        in_cfg.span = cfg_span;
        in_cfg.bip  = cfg_bip;
        in_cfg.pd   = cfg_pd;
    end

    always_comb begin
        c_d       = c_q;
        c_d.res_v = 1'b0;
        sar_start = 1'b0;
        sar_abort = !shdn_n;
        pd_apply  = 1'b0;
        if (!shdn_n) begin
            c_d.phase  = PH_IDLE;
            c_d.pend_v = 1'b0;
        end else begin
            unique case (c_q.phase)
                PH_IDLE: begin
                    if (cfg_strobe && core_en) begin
                        c_d.act   = in_cfg;
                        c_d.phase = PH_ACQ;
                    end
                end
                PH_ACQ: begin
                    if (cfg_strobe) begin
                        c_d.act = in_cfg;
                    end else if (stop_strobe) begin
                        c_d.phase = PH_CONV;
                        sar_start = 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cfg_strobe) begin
                        c_d.pend   = in_cfg;
                        c_d.pend_v = 1'b1;
                    end
                    if (sar_done) begin
                        c_d.res   = fmt_code;
                        c_d.res_v = 1'b1;
                        if (c_q.pend_v || cfg_strobe) begin
                            c_d.act    = cfg_strobe ? in_cfg : c_q.pend;
                            c_d.pend_v = 1'b0;
                            c_d.phase  = PH_ACQ;
                        end else begin
                            c_d.phase = PH_IDLE;
                            pd_apply  = 1'b1;
                        end
                    end
                end
                default: c_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    adc_sar_engine #(.BITS(BITS), .CLK_DIV(CLK_DIV)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sar_start),
        .abort  (sar_abort),
        .cmp_in (cmp_in),
        .trial  (sar_dac),
        .done   (sar_done),
        .code   (sar_code)
    );

    adc_code_fmt #(.BITS(BITS)) u_fmt (
        .raw  (sar_code),
        .bip  (c_q.act.bip),
        .code (fmt_code)
    );

    adc_power_ctrl u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .apply      (pd_apply),
        .pd_req     (c_q.act.pd),
        .wake       (wake_strobe),
        .core_en    (core_en),
        .ref_buf_en (ref_buf_en)
    );

    assign th_track     = (c_q.phase == PH_ACQ);
    assign conv_busy    = (c_q.phase == PH_CONV);
    assign mux_sel      = c_q.act.chan;
    assign rng_sel      = c_q.act.span;
    assign bip_sel      = c_q.act.bip;
    assign result       = c_q.res;
    assign result_valid = c_q.res_v;

    // R8: the core is never powered down under a running conversion
    assert_busy_core_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> core_en);

    // R4: a result only appears straight after a conversion
    assert_valid_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(conv_busy) && !conv_busy));

    // R11: the output register changes only with a result pulse
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    // R12: the selects do not move while a conversion keeps running
    assert_sel_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy)) |-> ($stable(mux_sel) && $stable(bip_sel)));

    // R3: a stop with no open window starts nothing
    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && stop_strobe && !th_track && !conv_busy) |=> !conv_busy);

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int BITS     = 12;
    localparam int CLK_DIV  = 4;
    localparam int CONV_CYC = BITS * CLK_DIV + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_strobe = 1'b0, cfg_span = 1'b0, cfg_bip = 1'b0;
    logic [2:0] cfg_chan = '0;
    logic [1:0] cfg_pd = '0;
    logic stop_strobe = 1'b0, wake_strobe = 1'b0, shdn_n = 1'b1;
    logic cmp_in;
    logic th_track, rng_sel, bip_sel, conv_busy, core_en, ref_buf_en, result_valid;
    logic [2:0] mux_sel;
    logic [BITS-1:0] sar_dac, result;
    logic [BITS-1:0] vin = '0;

    int checks = 0;
    int errors = 0;
    logic [BITS-1:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    assign cmp_in = (vin >= sar_dac);

    adc_seq_ctrl #(.BITS(BITS), .CLK_DIV(CLK_DIV)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .cfg_chan(cfg_chan),
        .cfg_span(cfg_span), .cfg_bip(cfg_bip), .cfg_pd(cfg_pd),
        .stop_strobe(stop_strobe), .wake_strobe(wake_strobe), .shdn_n(shdn_n),
        .cmp_in(cmp_in), .th_track(th_track), .mux_sel(mux_sel), .rng_sel(rng_sel),
        .bip_sel(bip_sel), .sar_dac(sar_dac), .conv_busy(conv_busy),
        .core_en(core_en), .ref_buf_en(ref_buf_en), .result(result),
        .result_valid(result_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 result pulse with nothing expected", 1, 0);
            end else begin
                chk(tag_q.pop_front(), result, exp_q.pop_front());
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cfg(input logic [2:0] ch, input logic sp, input logic bp, input logic [1:0] pd);
        cfg_chan = ch; cfg_span = sp; cfg_bip = bp; cfg_pd = pd;
        cfg_strobe = 1'b1;
        tick(1);
        cfg_strobe = 1'b0;
    endtask

    task automatic send_stop;
        stop_strobe = 1'b1;
        tick(1);
        stop_strobe = 1'b0;
    endtask

    task automatic pulse_wake;
        wake_strobe = 1'b1;
        tick(1);
        wake_strobe = 1'b0;
    endtask

    // driver: push the expected code, close the window, time the conversion
    task automatic run_conv(input logic [BITS-1:0] v, input logic bp, input string req);
        int n;
        vin = v;
        exp_q.push_back(bp ? (v ^ 12'h800) : v);
        tag_q.push_back(req);
        send_stop;
        chk("R3 busy after stop", conv_busy, 1);
        chk("R3 track closed after stop", th_track, 0);
        n = 0;
        while (conv_busy && n < 400) begin
            n++;
            tick(1);
        end
        chk("R4 busy length", n, CONV_CYC);
        chk("R4 valid with busy fall", result_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 result", result, 0);
        chk("R1 valid", result_valid, 0);
        chk("R1 track", th_track, 0);
        chk("R1 busy", conv_busy, 0);
        chk("R1 core_en", core_en, 1);
        chk("R1 ref_buf_en", ref_buf_en, 1);

        // R3 stop with no open window
        send_stop;
        tick(1);
        chk("R3 idle stop ignored", conv_busy, 0);

        // R2 R5 unipolar conversion
        send_cfg(3'd3, 1'b1, 1'b0, 2'b00);
        chk("R2 track", th_track, 1);
        chk("R2 mux_sel", mux_sel, 3);
        chk("R2 rng_sel", rng_sel, 1);
        chk("R2 bip_sel", bip_sel, 0);
        run_conv(12'hA5C, 1'b0, "R5 unipolar 0xA5C");
        send_cfg(3'd5, 1'b0, 1'b0, 2'b01);
        chk("R2 mux_sel second", mux_sel, 5);
        run_conv(12'hFFF, 1'b0, "R5 unipolar full scale");
        send_cfg(3'd0, 1'b0, 1'b0, 2'b00);
        run_conv(12'h000, 1'b0, "R5 unipolar zero");
        chk("R7 pd 0X core stays on", core_en, 1);
        send_cfg(3'd4, 1'b0, 1'b0, 2'b01);
        run_conv(12'h3C7, 1'b0, "R4 irregular pattern");
        tick(1);
        chk("R7 pd 01 core stays on", core_en, 1);
        chk("R7 pd 01 ref stays on", ref_buf_en, 1);

        // R6 bipolar coding
        send_cfg(3'd7, 1'b1, 1'b1, 2'b00);
        chk("R2 bip_sel", bip_sel, 1);
        run_conv(12'h000, 1'b1, "R6 bipolar -FS");
        send_cfg(3'd7, 1'b1, 1'b1, 2'b00);
        run_conv(12'hFFF, 1'b1, "R6 bipolar +FS");
        send_cfg(3'd7, 1'b1, 1'b1, 2'b00);
        run_conv(12'h800, 1'b1, "R6 bipolar zero");
        send_cfg(3'd7, 1'b1, 1'b1, 2'b00);
        run_conv(12'h7FF, 1'b1, "R6 bipolar -1");

        // R7 standby, R11 readable and cfg ignored, R9 wake
        send_cfg(3'd2, 1'b0, 1'b0, 2'b10);
        run_conv(12'h456, 1'b0, "R7 standby conversion");
        tick(1);
        chk("R7 standby core off", core_en, 0);
        chk("R7 standby ref on", ref_buf_en, 1);
        chk("R11 result held in standby", result, 12'h456);
        send_cfg(3'd6, 1'b0, 1'b0, 2'b00);
        chk("R11 cfg ignored while down", th_track, 0);
        chk("R11 mux unchanged while down", mux_sel, 2);
        tick(5);
        chk("R11 result still held", result, 12'h456);
        pulse_wake;
        chk("R9 wake core on", core_en, 1);

        // R8 full power-down
        send_cfg(3'd1, 1'b0, 1'b0, 2'b11);
        run_conv(12'h9A1, 1'b0, "R8 full pd conversion");
        tick(1);
        chk("R8 full core off", core_en, 0);
        chk("R8 full ref off", ref_buf_en, 0);
        chk("R11 result held in full pd", result, 12'h9A1);
        pulse_wake;
        chk("R9 wake core on after full", core_en, 1);
        chk("R9 wake ref on after full", ref_buf_en, 1);

        // R10 shutdown aborts a conversion
        send_cfg(3'd0, 1'b1, 1'b0, 2'b00);
        vin = 12'h300;
        send_stop;
        tick(20);
        shdn_n = 1'b0;
        tick(1);
        chk("R10 busy cleared", conv_busy, 0);
        chk("R10 track cleared", th_track, 0);
        chk("R10 core off", core_en, 0);
        chk("R10 ref off", ref_buf_en, 0);
        tick(CONV_CYC + 10);
        chk("R10 result unchanged", result, 12'h9A1);
        shdn_n = 1'b1;
        tick(2);
        chk("R10 core on after release", core_en, 1);
        send_cfg(3'd0, 1'b0, 1'b0, 2'b00);
        run_conv(12'h5A5, 1'b0, "R10 recovery conversion");

        // R12 control word held during a conversion
        send_cfg(3'd1, 1'b0, 1'b0, 2'b10);
        vin = 12'h123;
        exp_q.push_back(12'h123);
        tag_q.push_back("R12 old polarity used");
        send_stop;
        tick(10);
        send_cfg(3'd6, 1'b1, 1'b1, 2'b00);
        chk("R12 mux held", mux_sel, 1);
        chk("R12 bip held", bip_sel, 0);
        chk("R12 no track during conversion", th_track, 0);
        begin
            int w = 0;
            while (conv_busy && w < 400) begin
                w++;
                tick(1);
            end
        end
        chk("R12 new mux applied", mux_sel, 6);
        chk("R12 new bip applied", bip_sel, 1);
        chk("R12 acquisition opened", th_track, 1);
        chk("R12 standby skipped", core_en, 1);
        run_conv(12'h7FF, 1'b1, "R12 held word converts bipolar");

        tick(3);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule